// File: doc/BRIEF.md
# I2C Bus Master with Byte-Wide Register Control

This block is an I2C bus master that a host steers through five 8-bit registers on a simple synchronous bus. The bus has an address, write data, read data, a select and a write flag, and the block answers each access with a one-cycle acknowledge. The host first loads a 16-bit clock prescaler and sets the enable bit. It then places a byte in the transmit register and writes a command byte. The command byte holds one-shot request bits for START, write byte, read byte, STOP, the acknowledge value to send after a read, and an interrupt clear. The host polls the transfer-in-progress status bit until it drops, and then reads the received byte and the flags.

Both bus lines are open-drain. For each line the block has a data output that is always 0 and an active-low output enable, and it samples each line back through a two-stage synchronizer. Each bus bit is five prescaler phases long, and SDA moves only while SCL is low, except where a START or a STOP is being formed. The block watches the lines to track whether the bus is busy. It also reports lost arbitration when a '1' it released reads back as '0'.

Top module: `i2cm_core`

## Requirements
- R1: Registers on the 3-bit address: 0 prescaler low byte, 1 prescaler high byte, 2 control (bit 7 enable, bit 6 interrupt enable, other bits read 0), 3 transmit (write) / receive (read), 4 command (write) / status (read). Prescaler bytes and control read back what was written.
- R2: An access with `reg_sel` high is acknowledged by `reg_ack` high for exactly one cycle on the next clock edge, with `reg_rdata` valid in that same cycle.
- R3: While bits are being clocked, the SCL period is 5 × (prescaler + 1) system clocks.
- R4: Command bit 7 forms a START, in which SDA falls while SCL is high. A START issued again without a STOP is a repeated START, and bit 0 of the transmit byte then selects the direction (1 read, 0 write).
- R5: Command bit 4 sends the transmit byte MSB first. Within a byte, SDA changes only while SCL is low.
- R6: After a written byte, the acknowledge bit sampled from the slave appears in status bit 7 (1 means NACK).
- R7: Command bit 5 (with bit 4 clear) reads one byte MSB first into the receive register. In the acknowledge slot the master drives SDA to the value of command bit 3 (0 means ACK).
- R8: Status bit 1 (transfer in progress) reads 1 right after a command is accepted and reads 0 once the byte, its acknowledge and any STOP are finished.
- R9: Command bit 6 forms a STOP, in which SDA rises while SCL is high. Status bit 6 is 1 from a START seen on the lines until a STOP seen on the lines.
- R10: Status bit 0 is set when a transfer finishes. Command bit 0 clears it. The `irq` output equals status bit 0 AND control bit 6.
- R11: While control bit 7 is 0, commands have no effect: status bit 1 stays 0 and both lines stay released.
- R12: If SDA reads 0 during SCL high while the master released it for a data '1', the block sets status bit 5, aborts the transfer, releases both lines and sets status bit 0.
- R13: `scl_o` and `sda_o` are 0 at all times, so a line is only ever pulled low or released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid with reg_ack |
| reg_wr | input | 1 | 1 = write access, 0 = read access |
| reg_sel | input | 1 | Access request |
| reg_ack | output | 1 | One-cycle access acknowledge |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line sampled |
| scl_o | output | 1 | SCL data output (constant 0) |
| scl_oe_n | output | 1 | SCL active-low output enable |
| sda_i | input | 1 | SDA line sampled |
| sda_o | output | 1 | SDA data output (constant 0) |
| sda_oe_n | output | 1 | SDA active-low output enable |

## Verification
Clearing the interrupt flag and launching a new transfer can happen in the same register write. The bench writes 0x41 (STOP plus interrupt clear) while the flag is set. It then expects the next status read to show the transfer running and the flag clear, and the flag set again only after the STOP completes. A transfer can also finish on the same edge as an interrupt clear. The design gives completion the priority, and a checker property ties every fall of the in-progress bit to a set flag. A behavioural slave and a line monitor run on every clock. They decode bytes, acknowledges, START/STOP counts and SCL periods, and the bench compares these with values computed from the requirements.

// File: rtl/i2cm_core.sv
module i2cm_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       reg_wr,
  input  logic       reg_sel,
  output logic       reg_ack,
  output logic       irq,
  input  logic       scl_i,
  output logic       scl_o,
  output logic       scl_oe_n,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe_n
);
  localparam int PW = 16;
  localparam logic [2:0] PH_LAST = 3'd4;
  localparam logic [2:0] PH_SMP  = 3'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_ACK, S_STOP} st_t;

  logic [PW-1:0] pre, cnt;
  logic          en, ien;
  logic [7:0]    txr, rxr, sr;
  logic          rxack, al, tip, ifl, busy;
  logic          c_sto, c_wr, c_rd, c_nack;
  st_t           st;
  logic [2:0]    ph, bitn;
  logic          rxbit;
  logic          scl_q, sda_q, scl_n, sda_n;
  logic          scl_m, scl_s, sda_m, sda_s, sda_p;

  wire acc  = reg_sel & ~reg_ack;
  wire wen  = acc & reg_wr;
  wire tick = (cnt == '0);
  wire smp  = tick && (ph == PH_SMP);
  wire last = tick && (ph == PH_LAST);
  wire go   = wen && (reg_addr == 3'd4) && en && !tip && (|reg_wdata[7:4]);

  assign scl_o    = 1'b0;
  assign sda_o    = 1'b0;
  assign scl_oe_n = scl_q;
  assign sda_oe_n = sda_q;
  assign irq      = ien & ifl;

  always_comb begin
    scl_n = scl_q;
    sda_n = sda_q;
    case (st)
      S_START: begin scl_n = (ph != 3'd0) && (ph != 3'd4); sda_n = (ph < 3'd3); end
      S_BITS:  begin scl_n = (ph == 3'd2) || (ph == 3'd3); sda_n = c_rd ? 1'b1 : sr[7]; end
      S_ACK:   begin scl_n = (ph == 3'd2) || (ph == 3'd3); sda_n = c_rd ? c_nack : 1'b1; end
      S_STOP:  begin scl_n = (ph != 3'd0); sda_n = (ph >= 3'd3); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; cnt <= '0; en <= 1'b0; ien <= 1'b0;
      txr <= '0; rxr <= '0; sr <= '0;
      rxack <= 1'b0; al <= 1'b0; tip <= 1'b0; ifl <= 1'b0; busy <= 1'b0;
      c_sto <= 1'b0; c_wr <= 1'b0; c_rd <= 1'b0; c_nack <= 1'b0;
      st <= S_IDLE; ph <= '0; bitn <= '0; rxbit <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
      scl_m <= 1'b1; scl_s <= 1'b1; sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
      reg_ack <= 1'b0; reg_rdata <= '0;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
      if (scl_s && sda_p && !sda_s) busy <= 1'b1;
      else if (scl_s && !sda_p && sda_s) busy <= 1'b0;

      reg_ack <= acc;
      if (acc) begin
        case (reg_addr)
          3'd0:    reg_rdata <= pre[7:0];
          3'd1:    reg_rdata <= pre[15:8];
          3'd2:    reg_rdata <= {en, ien, 6'b0};
          3'd3:    reg_rdata <= rxr;
          3'd4:    reg_rdata <= {rxack, busy, al, 3'b0, tip, ifl};
          default: reg_rdata <= '0;
        endcase
      end
      if (wen) begin
        case (reg_addr)
          3'd0: pre[7:0]  <= reg_wdata;
          3'd1: pre[15:8] <= reg_wdata;
          3'd2: begin en <= reg_wdata[7]; ien <= reg_wdata[6]; end
          3'd3: txr <= reg_wdata;
          3'd4: if (reg_wdata[0]) ifl <= 1'b0;
          default: ;
        endcase
      end

      if (!en) begin
        st <= S_IDLE; tip <= 1'b0;
        scl_q <= 1'b1; sda_q <= 1'b1;
      end else begin
        scl_q <= scl_n;
        sda_q <= sda_n;
        if (go) begin
          c_sto  <= reg_wdata[6];
          c_wr   <= reg_wdata[4];
          c_rd   <= reg_wdata[5] & ~reg_wdata[4];
          c_nack <= reg_wdata[3];
          tip <= 1'b1; al <= 1'b0;
          sr <= txr; cnt <= pre; ph <= '0; bitn <= '0;
          if (reg_wdata[7])                      st <= S_START;
          else if (reg_wdata[4] | reg_wdata[5])  st <= S_BITS;
          else                                   st <= S_STOP;
        end else if (st != S_IDLE) begin
          if (tick) begin
            cnt <= pre;
            ph  <= (ph == PH_LAST) ? 3'd0 : ph + 3'd1;
          end else begin
            cnt <= cnt - 1'b1;
          end
          if (smp) begin
            rxbit <= sda_s;
            if (st == S_ACK && !c_rd) rxack <= sda_s;
            if (st == S_BITS && !c_rd && sr[7] && !sda_s) begin
              al <= 1'b1; tip <= 1'b0; ifl <= 1'b1; st <= S_IDLE;
              scl_q <= 1'b1; sda_q <= 1'b1;
            end
          end
          if (last) begin
            case (st)
              S_START: begin
                if (c_wr | c_rd) begin st <= S_BITS; bitn <= '0; end
                else if (c_sto) st <= S_STOP;
                else begin st <= S_IDLE; tip <= 1'b0; ifl <= 1'b1; end
              end
              S_BITS: begin
                sr <= {sr[6:0], rxbit};
                if (bitn == 3'd7) begin
                  st <= S_ACK;
                  if (c_rd) rxr <= {sr[6:0], rxbit};
                end else begin
                  bitn <= bitn + 3'd1;
                end
              end
              S_ACK: begin
                if (c_sto) st <= S_STOP;
                else begin st <= S_IDLE; tip <= 1'b0; ifl <= 1'b1; end
              end
              S_STOP: begin st <= S_IDLE; tip <= 1'b0; ifl <= 1'b1; end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_core_chk.sv
module i2cm_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       tip,
  input logic       ifl,
  input logic       al,
  input logic [2:0] st,
  input logic       scl_oe_n,
  input logic       sda_oe_n,
  input logic       reg_ack
);
  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack |=> !reg_ack);

  // R8
  tip_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tip) && $past(en)) |-> ifl);

  // R11
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tip && scl_oe_n && sda_oe_n));

  // R12
  al_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al) |-> (scl_oe_n && sda_oe_n && !tip));

  // R5
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && $past(st) == 3'd2 && scl_oe_n && $past(scl_oe_n)) |-> $stable(sda_oe_n));
endmodule

bind i2cm_core i2cm_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tip(tip), .ifl(ifl), .al(al),
  .st(st), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .reg_ack(reg_ack)
);

// File: tb/i2cm_core_bench.sv
`timescale 1ns/1ps
module i2cm_core_bench;
  localparam logic [6:0] SADR = 7'h10;
  localparam int PRE = 4;
  localparam int PER = 5 * (PRE + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic reg_wr = 1'b0, reg_sel = 1'b0, reg_ack, irq;
  logic scl_o, scl_oe_n, sda_o, sda_oe_n;
  logic slv_low = 1'b0, frc_low = 1'b0;

  wire scl_ln = scl_oe_n | scl_o;
  wire sda_ln = (sda_oe_n | sda_o) & ~slv_low & ~frc_low;

  always #4 clk = ~clk;

  i2cm_core u_i2cm_core (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_ack(reg_ack),
    .irq(irq), .scl_i(scl_ln), .scl_o(scl_o), .scl_oe_n(scl_oe_n),
    .sda_i(sda_ln), .sda_o(sda_o), .sda_oe_n(sda_oe_n)
  );

  int tests = 0, fails = 0, cyc = 0;
  logic exp_en = 1'b0;
  logic last_ack;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 3'd2) exp_en = d[7];
    @(negedge clk);
    last_ack = reg_ack;
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata; last_ack = reg_ack;
    reg_sel = 1'b0;
  endtask

  task automatic poll(output logic [7:0] s);
    int n = 0;
    rd(3'd4, s);
    while (s[1] && n < 5000) begin rd(3'd4, s); n++; end
  endtask

  // line monitor and behavioural slave, sampled at the falling clock edge
  logic ps = 1'b1, pd = 1'b1;
  int n_start = 0, n_stop = 0, n_rise = 0, mbit = 0, last_rise = 0;
  int per_min = 1 << 30, per_max = 0;
  logic [7:0] mbyte = '0;
  logic [7:0] mq[$];
  logic       maq[$];
  logic [7:0] srxq[$];
  bit s_act = 0, s_adr = 0, s_tx = 0, s_match = 0, s_mack = 0;
  int s_cnt = 0, s_idx = 0;
  logic [7:0] s_byte = '0, s_cur = '0;

  function automatic logic [7:0] txbyte(input int i);
    if (i == 0) return 8'hA5;
    if (i == 1) return 8'h5A;
    return 8'(i * 17);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      // R13
      if (scl_o !== 1'b0 || sda_o !== 1'b0) chk(0, "R13 pad data", {scl_o, sda_o}, 0);
      // R11
      if (!exp_en && (scl_oe_n !== 1'b1 || sda_oe_n !== 1'b1))
        chk(0, "R11 released while disabled", {scl_oe_n, sda_oe_n}, 3);
      if (ps && scl_ln && pd && !sda_ln) begin
        n_start++; mbit = 0; s_act = 1; s_adr = 1; s_tx = 0; s_cnt = 0; slv_low <= 1'b0;
      end else if (ps && scl_ln && !pd && sda_ln) begin
        n_stop++; s_act = 0; slv_low <= 1'b0;
      end
      if (!ps && scl_ln) begin
        n_rise++;
        if (mbit > 0) begin
          if (cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        if (mbit < 8) begin mbyte = {mbyte[6:0], sda_ln}; mbit++; end
        else begin mq.push_back(mbyte); maq.push_back(sda_ln); mbit = 0; end
        last_rise = cyc;
        if (s_act) begin
          if (s_cnt < 8) s_byte = {s_byte[6:0], sda_ln};
          else if (s_tx) s_mack = sda_ln;
          s_cnt++;
        end
      end
      if (ps && !scl_ln && s_act) begin
        if (s_cnt == 8) begin
          if (s_adr) begin
            s_match = (s_byte[7:1] == SADR); s_tx = s_byte[0]; slv_low <= s_match;
          end else if (!s_tx) begin
            srxq.push_back(s_byte); slv_low <= 1'b1;
          end else slv_low <= 1'b0;
        end else if (s_cnt == 9) begin
          s_cnt = 0; slv_low <= 1'b0;
          if (!s_match) s_act = 0;
          else if (s_tx && (s_adr || !s_mack)) begin
            s_cur = txbyte(s_idx); s_idx++; slv_low <= !s_cur[7];
          end else if (s_tx) s_act = 0;
          s_adr = 0;
        end else if (s_tx && !s_adr && s_cnt >= 1 && s_cnt <= 7) begin
          slv_low <= !s_cur[7 - s_cnt];
        end
      end
      ps = scl_ln; pd = sda_ln;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, s;
    int k, r;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd(3'd4, s);
    chk(s == 8'h00, "R1 status after reset", s, 8'h00);
    chk(scl_oe_n && sda_oe_n && !irq, "R13 lines released after reset", {scl_oe_n, sda_oe_n, irq}, 6);

    wr(3'd0, 8'hC8); rd(3'd0, d);
    chk(d == 8'hC8, "R1 prescaler low", d, 8'hC8);
    chk(last_ack == 1'b1, "R2 ack with read data", last_ack, 1);
    @(negedge clk);
    chk(reg_ack == 1'b0, "R2 ack single cycle", reg_ack, 0);
    wr(3'd1, 8'h5A); rd(3'd1, d);
    chk(d == 8'h5A, "R1 prescaler high", d, 8'h5A);
    wr(3'd2, 8'hFF); rd(3'd2, d);
    chk(d == 8'hC0, "R1 control readback", d, 8'hC0);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'(PRE)); wr(3'd1, 8'h00);

    // R11: disabled core ignores commands
    wr(3'd3, {SADR, 1'b0}); wr(3'd4, 8'h90);
    repeat (200) @(negedge clk);
    rd(3'd4, s);
    chk(s[1] == 1'b0 && n_start == 0, "R11 command ignored", {s, 8'(n_start)}, 0);

    wr(3'd2, 8'hC0);
    // address write
    wr(3'd3, {SADR, 1'b0}); wr(3'd4, 8'h90);
    rd(3'd4, s);
    chk(s[1] == 1'b1, "R8 tip set after command", s, 8'h02);
    poll(s);
    chk(s == 8'h41, "R6 R8 R9 status after address ack", s, 8'h41);
    chk(irq == 1'b1, "R10 irq raised", irq, 1);
    chk(n_start == 1 && mq.size() == 1 && mq[0] == 8'h20 && maq[0] == 1'b0,
        "R4 R5 start and address byte", mq.size() > 0 ? int'(mq[0]) : -1, 8'h20);
    chk(per_min == PER && per_max == PER, "R3 scl period", per_min * 1000 + per_max, PER * 1000 + PER);
    wr(3'd4, 8'h01);
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);

    wr(3'd3, 8'h3C); wr(3'd4, 8'h10);
    poll(s);
    chk(srxq.size() == 1 && srxq[0] == 8'h3C && s[7] == 1'b0, "R5 R6 data byte",
        srxq.size() > 0 ? int'(srxq[0]) : -1, 8'h3C);

    wr(3'd4, 8'h01);
    wr(3'd3, {SADR, 1'b1}); wr(3'd4, 8'h90);
    poll(s);
    chk(n_start == 2 && n_stop == 0 && s == 8'h41, "R4 repeated start read address", {8'(n_start), s}, 16'h0241);
    wr(3'd4, 8'h01);
    wr(3'd4, 8'h20);
    poll(s); rd(3'd3, d);
    chk(d == 8'hA5, "R7 first read byte", d, 8'hA5);
    chk(maq.size() == 4 && maq[3] == 1'b0, "R7 master ack driven", maq.size() == 4 ? int'(maq[3]) : -1, 0);
    wr(3'd4, 8'h01);
    wr(3'd4, 8'h68);
    poll(s); rd(3'd3, d);
    chk(d == 8'h5A, "R7 second read byte", d, 8'h5A);
    chk(maq.size() == 5 && maq[4] == 1'b1, "R7 master nack driven", maq.size() == 5 ? int'(maq[4]) : -1, 1);
    chk(n_stop == 1 && s == 8'h01, "R9 stop and busy clear", {8'(n_stop), s}, 16'h0101);
    chk(per_min == PER && per_max == PER, "R3 scl period over reads", per_min * 1000 + per_max, PER * 1000 + PER);

    // unanswered address, then stop combined with interrupt clear
    wr(3'd4, 8'h01);
    wr(3'd3, 8'h40); wr(3'd4, 8'h90);
    poll(s);
    chk(s == 8'hC1, "R6 nack reported", s, 8'hC1);
    wr(3'd4, 8'h41);
    rd(3'd4, s);
    chk(s[1] == 1'b1 && s[0] == 1'b0, "R10 clear with stop launch", s, 8'hC2);
    poll(s);
    chk(s[0] == 1'b1 && s[6] == 1'b0 && n_stop == 2, "R9 R10 stop completion", s, 8'h81);
    wr(3'd2, 8'h80);
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
    wr(3'd2, 8'hC0);
    wr(3'd4, 8'h01);

    // R12: lost arbitration
    k = n_start;
    wr(3'd3, 8'hFF); wr(3'd4, 8'h90);
    wait (n_start > k);
    r = n_rise;
    wait (n_rise > r);
    @(negedge clk) frc_low = 1'b1;
    poll(s);
    chk(s[5] == 1'b1 && s[1] == 1'b0 && s[0] == 1'b1, "R12 arbitration lost flag", s, 8'h21);
    chk(scl_oe_n && sda_oe_n, "R12 lines released", {scl_oe_n, sda_oe_n}, 3);
    @(negedge clk) frc_low = 1'b0;
    repeat (20) @(negedge clk);
    rd(3'd4, s);
    chk(s[6] == 1'b0, "R9 busy cleared by line stop", s[6], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule